// File: doc/BRIEF.md
# USB Device Address Control Unit

This block holds the device address and the enable state of a full-speed USB peripheral. A microcontroller reaches it through a byte-wide command port. It pulses `cmd_stb` with a command code, then moves one data byte with `dat_wr_stb` or `dat_rd_stb`. The unit keeps two copies of the address. The programmed register is what the micro writes and reads back. The effective address is what the packet engine compares against incoming token addresses.

A newly programmed address does not take effect at once. It waits, flagged as pending, until the host acknowledges a zero-length IN packet on the control endpoint, which is the status stage of the address-setting transfer. A USB bus reset forces the effective address to zero and enables the device, but leaves the programmed register alone. Commands that carry endpoint configuration are decoded only far enough to be handed on to the endpoint logic.

Top module: `usb_addr_ctl`

## Requirements
- R1: While `rst_n` is low and after its release, the programmed register, the effective address, the device-enable flag and the pending flag are all zero.
- R2: A `cmd_stb` with code 0xB6 followed by a `dat_wr_stb` stores the data byte in the programmed register and sets `addr_pending` on the next clock.
- R3: After a `cmd_stb` with code 0xB7, a `dat_rd_stb` raises `rd_ack` in the same cycle. `rd_data` then shows the programmed register, even while that value is pending. `rd_data` is zero whenever `rd_ack` is low.
- R4: `dev_addr` changes only on a bus reset or on a qualifying acknowledge. A qualifying acknowledge is `in_ack` high with `in_ack_ep` equal to 0 and `in_ack_zlp` high while an update is pending. On a qualifying acknowledge, `dev_addr` takes bits 6..0 of the programmed register and `addr_pending` clears.
- R5: An acknowledge on another endpoint, an acknowledge of a non-empty packet, or an acknowledge with no update pending changes neither `dev_addr` nor `addr_pending`.
- R6: A `bus_rst` pulse sets `dev_addr` to 0 and `dev_en` to 1 and clears `addr_pending` on the next clock. The programmed register, as read back through 0xB7, keeps its value.
- R7: Bit 7 of a byte written after 0xB6 is the enable flag. It reaches `dev_en` on the next clock, without waiting for an acknowledge.
- R8: `tok_match` is high in the same cycle exactly when `dev_en` is 1 and `tok_addr` equals `dev_addr`. With the device disabled, no address matches.
- R9: A command code in 0x20..0x3F raises `pass_stb` in the same cycle. `pass_ep` equals code bits 3..0, and `pass_wr` is high for 0x20..0x2F and low for 0x30..0x3F. The data byte that follows changes nothing in this block and gets no `rd_ack`.
- R10: A data byte written after any command code other than 0xB6 changes neither the register nor the pending flag.
- R11: Each address command moves exactly one data byte. A second `dat_wr_stb` or `dat_rd_stb` without a new command has no effect.
- R12: When the address-write byte and `bus_rst` arrive in the same cycle, the register takes the byte and stays pending, and `dev_addr`=0 and `dev_en`=1. When the address-write byte and a qualifying acknowledge arrive in the same cycle, `dev_addr` takes the previously programmed address and the new byte stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cmd_stb | input | 1 | Command code strobe |
| cmd_code | input | 8 | Command code |
| dat_wr_stb | input | 1 | Data byte write strobe |
| dat_wr | input | 8 | Data byte written by the micro |
| dat_rd_stb | input | 1 | Data byte read strobe |
| rd_data | output | 8 | Read data (programmed register) |
| rd_ack | output | 1 | Read accepted by this block |
| pass_stb | output | 1 | Endpoint configuration command seen |
| pass_wr | output | 1 | Pass-through command is a write |
| pass_ep | output | 4 | Endpoint index of pass-through command |
| bus_rst | input | 1 | USB bus reset pulse |
| in_ack | input | 1 | Host acknowledged an IN packet |
| in_ack_ep | input | 4 | Endpoint of acknowledged IN packet |
| in_ack_zlp | input | 1 | Acknowledged IN packet had zero length |
| tok_addr | input | 7 | Address field of incoming token |
| tok_match | output | 1 | Token addressed to this device |
| dev_addr | output | 7 | Effective device address |
| dev_en | output | 1 | Effective device enable |
| addr_pending | output | 1 | Programmed address awaits status-stage ACK |

## Verification
Three pairs of functions can collide in the same clock cycle. The address-write byte can arrive together with a bus reset. It can arrive together with the status-stage acknowledge that applies an earlier pending address. A new command strobe can arrive together with a data strobe. The bench forces each collision on purpose and then drives a long run of random mixed strobes so the collisions also occur by chance. A behavioural model applies the stated priorities: bus reset wins for the effective state, the write wins for the pending flag, and an acknowledge loads the register value from before the write. The model's output is compared with the design's outputs after every clock.

// File: rtl/usb_addr_ctl.sv
module usb_addr_ctl #(
  parameter int AW = 7,
  parameter logic [7:0] CMD_ADDR_WR = 8'hB6,
  parameter logic [7:0] CMD_ADDR_RD = 8'hB7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_stb,
  input  logic [7:0]    cmd_code,
  input  logic          dat_wr_stb,
  input  logic [AW:0]   dat_wr,
  input  logic          dat_rd_stb,
  output logic [AW:0]   rd_data,
  output logic          rd_ack,
  output logic          pass_stb,
  output logic          pass_wr,
  output logic [3:0]    pass_ep,
  input  logic          bus_rst,
  input  logic          in_ack,
  input  logic [3:0]    in_ack_ep,
  input  logic          in_ack_zlp,
  input  logic [AW-1:0] tok_addr,
  output logic          tok_match,
  output logic [AW-1:0] dev_addr,
  output logic          dev_en,
  output logic          addr_pending
);
  localparam int RW = AW + 1;

  typedef enum logic [1:0] {SEL_IDLE, SEL_WR, SEL_RD} sel_t;

  sel_t          sel;
  logic [RW-1:0] addr_reg;
  logic          wr_hit;
  logic          apply;

  assign wr_hit   = dat_wr_stb && (sel == SEL_WR);
  assign rd_ack   = dat_rd_stb && (sel == SEL_RD);
  assign rd_data  = rd_ack ? addr_reg : '0;
  assign apply    = addr_pending && in_ack && (in_ack_ep == 4'd0) && in_ack_zlp;

  assign pass_stb = cmd_stb && (cmd_code[7:5] == 3'b001);
  assign pass_wr  = ~cmd_code[4];
  assign pass_ep  = cmd_code[3:0];

  assign tok_match = dev_en && (tok_addr == dev_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= SEL_IDLE;
    end else if (cmd_stb) begin
      if (cmd_code == CMD_ADDR_WR)      sel <= SEL_WR;
      else if (cmd_code == CMD_ADDR_RD) sel <= SEL_RD;
      else                              sel <= SEL_IDLE;
    end else if (wr_hit || rd_ack) begin
      sel <= SEL_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_reg     <= '0;
      addr_pending <= 1'b0;
      dev_addr     <= '0;
      dev_en       <= 1'b0;
    end else begin
      if (wr_hit) addr_reg <= dat_wr;

      if (wr_hit)                 addr_pending <= 1'b1;
      else if (bus_rst || apply)  addr_pending <= 1'b0;

      if (bus_rst)    dev_addr <= '0;
      else if (apply) dev_addr <= addr_reg[AW-1:0];

      if (bus_rst)     dev_en <= 1'b1;
      else if (wr_hit) dev_en <= dat_wr[AW];
    end
  end
endmodule

// File: rtl/usb_addr_ctl_chk.sv
module usb_addr_ctl_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rst,
  input logic          in_ack,
  input logic [3:0]    in_ack_ep,
  input logic          in_ack_zlp,
  input logic          dat_wr_stb,
  input logic          cmd_stb,
  input logic          pass_stb,
  input logic          rd_ack,
  input logic [AW:0]   rd_data,
  input logic [AW:0]   addr_reg,
  input logic [AW-1:0] dev_addr,
  input logic          dev_en,
  input logic          addr_pending,
  input logic          tok_match
);
  logic qual_ack;
  assign qual_ack = in_ack && (in_ack_ep == 4'd0) && in_ack_zlp;

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rst && !(qual_ack && addr_pending)) |=> $stable(dev_addr));

  p_apply_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_pending && qual_ack && !bus_rst) |=> (dev_addr == $past(addr_reg[AW-1:0])));

  p_noapply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_pending && !dat_wr_stb) |=> !addr_pending);

  p_busrst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (dev_addr == '0) && dev_en);

  p_busrst_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst && !dat_wr_stb) |=> $stable(addr_reg));

  p_rdata_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> (rd_data == addr_reg));

  p_nomatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_en |-> !tok_match);

  p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pass_stb |-> cmd_stb);
endmodule

bind usb_addr_ctl usb_addr_ctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .in_ack(in_ack),
  .in_ack_ep(in_ack_ep), .in_ack_zlp(in_ack_zlp), .dat_wr_stb(dat_wr_stb),
  .cmd_stb(cmd_stb), .pass_stb(pass_stb), .rd_ack(rd_ack), .rd_data(rd_data),
  .addr_reg(addr_reg), .dev_addr(dev_addr), .dev_en(dev_en),
  .addr_pending(addr_pending), .tok_match(tok_match)
);

// File: tb/usb_addr_ctl_test.sv
module usb_addr_ctl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_stb = 0, dat_wr_stb = 0, dat_rd_stb = 0;
  logic [7:0] cmd_code = 0, dat_wr = 0;
  logic       bus_rst = 0, in_ack = 0, in_ack_zlp = 0;
  logic [3:0] in_ack_ep = 0;
  logic [6:0] tok_addr = 0;
  logic [7:0] rd_data;
  logic       rd_ack, pass_stb, pass_wr, tok_match, dev_en, addr_pending;
  logic [3:0] pass_ep;
  logic [6:0] dev_addr;

  int checks = 0, fails = 0;
  string cur_req = "R1";

  int m_reg = 0, m_pend = 0, m_eaddr = 0, m_en = 0, m_sel = 0;

  always #2 clk = ~clk;

  usb_addr_ctl uut (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
    .dat_wr_stb(dat_wr_stb), .dat_wr(dat_wr), .dat_rd_stb(dat_rd_stb),
    .rd_data(rd_data), .rd_ack(rd_ack), .pass_stb(pass_stb), .pass_wr(pass_wr),
    .pass_ep(pass_ep), .bus_rst(bus_rst), .in_ack(in_ack), .in_ack_ep(in_ack_ep),
    .in_ack_zlp(in_ack_zlp), .tok_addr(tok_addr), .tok_match(tok_match),
    .dev_addr(dev_addr), .dev_en(dev_en), .addr_pending(addr_pending)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s]: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int e_rd, e_pass;
    e_rd   = (dat_rd_stb && m_sel == 2) ? 1 : 0;
    e_pass = (cmd_stb && cmd_code[7:5] == 3'b001) ? 1 : 0;
    chk("R3 rd_ack", int'(rd_ack), e_rd);
    chk("R3 rd_data", int'(rd_data), e_rd ? m_reg : 0);
    chk("R9 pass_stb", int'(pass_stb), e_pass);
    if (e_pass) begin
      chk("R9 pass_wr", int'(pass_wr), cmd_code[4] ? 0 : 1);
      chk("R9 pass_ep", int'(pass_ep), int'(cmd_code[3:0]));
    end
    chk("R8 tok_match", int'(tok_match), (m_en && int'(tok_addr) == m_eaddr) ? 1 : 0);
    chk("R4 dev_addr", int'(dev_addr), m_eaddr);
    chk("R7 dev_en", int'(dev_en), m_en);
    chk("R2 addr_pending", int'(addr_pending), m_pend);
  endtask

  task automatic model_update();
    int wr_hit, rd_hit, apply;
    int n_reg, n_pend, n_eaddr, n_en, n_sel;
    wr_hit = (dat_wr_stb && m_sel == 1) ? 1 : 0;
    rd_hit = (dat_rd_stb && m_sel == 2) ? 1 : 0;
    apply  = (m_pend && in_ack && in_ack_ep == 0 && in_ack_zlp) ? 1 : 0;
    n_reg = m_reg; n_pend = m_pend; n_eaddr = m_eaddr; n_en = m_en; n_sel = m_sel;
    if (wr_hit) n_reg = int'(dat_wr);
    if (wr_hit) n_pend = 1; else if (bus_rst || apply) n_pend = 0;
    if (bus_rst) n_eaddr = 0; else if (apply) n_eaddr = m_reg & 8'h7F;
    if (bus_rst) n_en = 1; else if (wr_hit) n_en = int'(dat_wr[7]);
    if (cmd_stb) n_sel = (cmd_code == 8'hB6) ? 1 : (cmd_code == 8'hB7) ? 2 : 0;
    else if (wr_hit || rd_hit) n_sel = 0;
    m_reg = n_reg; m_pend = n_pend; m_eaddr = n_eaddr; m_en = n_en; m_sel = n_sel;
  endtask

  task automatic step(input logic c, input logic [7:0] code, input logic w,
                      input logic [7:0] wd, input logic r, input logic br,
                      input logic ak, input logic [3:0] aep, input logic zlp,
                      input logic [6:0] ta);
    cmd_stb = c; cmd_code = code; dat_wr_stb = w; dat_wr = wd; dat_rd_stb = r;
    bus_rst = br; in_ack = ak; in_ack_ep = aep; in_ack_zlp = zlp; tok_addr = ta;
    #1;
    compare_all();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle(input logic [6:0] ta);
    step(0, 8'h00, 0, 8'h00, 0, 0, 0, 4'd0, 0, ta);
  endtask

  task automatic wr_addr(input logic [7:0] v);
    step(1, 8'hB6, 0, 8'h00, 0, 0, 0, 4'd0, 0, 7'd0);
    step(0, 8'h00, 1, v, 0, 0, 0, 4'd0, 0, 7'd0);
  endtask

  task automatic rd_addr();
    step(1, 8'hB7, 0, 8'h00, 0, 0, 0, 4'd0, 0, 7'd0);
    step(0, 8'h00, 0, 8'h00, 1, 0, 0, 4'd0, 0, 7'd0);
  endtask

  task automatic zlp_ack(input logic [3:0] ep, input logic zlp);
    step(0, 8'h00, 0, 8'h00, 0, 0, 1, ep, zlp, 7'd0);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    #1;
    compare_all();
    rst_n = 1'b1;
    @(negedge clk);
    idle(7'd0);
    rd_addr();

    cur_req = "R2";
    wr_addr(8'h85);
    idle(7'd5);
    cur_req = "R3";
    rd_addr();

    cur_req = "R4";
    idle(7'd5);
    zlp_ack(4'd0, 1);
    idle(7'd5);
    idle(7'd0);

    cur_req = "R5";
    wr_addr(8'h8A);
    zlp_ack(4'd1, 1);
    zlp_ack(4'd0, 0);
    idle(7'd10);
    zlp_ack(4'd0, 1);
    zlp_ack(4'd0, 1);
    idle(7'd10);

    cur_req = "R7";
    wr_addr(8'h0A);
    cur_req = "R8";
    idle(7'd10);
    idle(7'd5);

    cur_req = "R6";
    step(0, 8'h00, 0, 8'h00, 0, 1, 0, 4'd0, 0, 7'd0);
    idle(7'd0);
    rd_addr();
    zlp_ack(4'd0, 1);
    idle(7'd0);

    cur_req = "R9";
    step(1, 8'h25, 0, 8'h00, 0, 0, 0, 4'd0, 0, 7'd0);
    step(0, 8'h00, 1, 8'hFF, 0, 0, 0, 4'd0, 0, 7'd0);
    step(1, 8'h33, 0, 8'h00, 0, 0, 0, 4'd0, 0, 7'd0);
    step(0, 8'h00, 0, 8'h00, 1, 0, 0, 4'd0, 0, 7'd0);
    step(1, 8'h2F, 0, 8'h00, 0, 0, 0, 4'd0, 0, 7'd0);
    step(1, 8'h40, 0, 8'h00, 0, 0, 0, 4'd0, 0, 7'd0);
    rd_addr();

    cur_req = "R10";
    step(1, 8'h55, 0, 8'h00, 0, 0, 0, 4'd0, 0, 7'd0);
    step(0, 8'h00, 1, 8'hC4, 0, 0, 0, 4'd0, 0, 7'd0);
    step(1, 8'hB5, 0, 8'h00, 0, 0, 0, 4'd0, 0, 7'd0);
    step(0, 8'h00, 1, 8'hC4, 0, 0, 0, 4'd0, 0, 7'd0);
    rd_addr();

    cur_req = "R11";
    wr_addr(8'h91);
    step(0, 8'h00, 1, 8'h92, 0, 0, 0, 4'd0, 0, 7'd0);
    rd_addr();
    step(0, 8'h00, 0, 8'h00, 1, 0, 0, 4'd0, 0, 7'd0);
    zlp_ack(4'd0, 1);
    idle(7'h11);

    cur_req = "R12";
    step(1, 8'hB6, 0, 8'h00, 0, 0, 0, 4'd0, 0, 7'd0);
    step(0, 8'h00, 1, 8'h33, 0, 1, 0, 4'd0, 0, 7'd0);
    idle(7'd0);
    rd_addr();
    wr_addr(8'h87);
    step(1, 8'hB6, 0, 8'h00, 0, 0, 0, 4'd0, 0, 7'd0);
    step(0, 8'h00, 1, 8'h9C, 0, 0, 1, 4'd0, 1, 7'd7);
    idle(7'd7);
    zlp_ack(4'd0, 1);
    idle(7'h1C);
    step(1, 8'hB7, 0, 8'h00, 1, 0, 0, 4'd0, 0, 7'd0);
    step(0, 8'h00, 0, 8'h00, 1, 0, 0, 4'd0, 0, 7'd0);

    cur_req = "R12 random";
    for (int i = 0; i < 3000; i++) begin
      int k;
      logic [7:0] code;
      k = $urandom_range(0, 7);
      code = (k < 3) ? 8'hB6 : (k < 5) ? 8'hB7 : (k == 5) ? 8'(8'h20 + $urandom_range(0, 31)) : 8'($urandom);
      step($urandom_range(0, 3) == 0, code, $urandom_range(0, 2) == 0, 8'($urandom),
           $urandom_range(0, 2) == 0, $urandom_range(0, 15) == 0,
           $urandom_range(0, 3) == 0, 4'($urandom_range(0, 2)), $urandom_range(0, 1) == 1,
           ($urandom_range(0, 1) == 1) ? 7'(m_eaddr) : 7'($urandom));
    end
    idle(7'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule